// File: doc/BRIEF.md
# Oversampled I2C Slave Byte Receiver

This block is the receive side of an I2C slave built for a bus whose open-drain rising edges are slow and noisy. SCL is never used as a clock. Both bus lines are brought into a fast system clock domain through two-flop synchronisers. A counter-based filter then turns each line into a clean level plus single-cycle rise and fall events. START and STOP are recognised from those events. Address and data bits are shifted in on clean SCL rises. The bit count advances on clean SCL falls.

The first byte after a START carries a 7-bit address and a direction bit. When the address matches and the transfer is a write, the block acknowledges by asserting an open-drain pull-down enable for the ninth clock. It then acknowledges and reports every following byte until the next START or STOP. Any other address byte makes the block stay silent until the bus is framed again.

Top module: `i2c_oversampled_slave`

## Requirements
- R1: After reset, sda_oe, byte_valid, start_det and stop_det are all 0, and both filtered lines read as high (idle bus).
- R2: A filtered line takes a new value only after its synchronised sample has shown that value for STABLE_CYCLES consecutive system clocks. A raw pulse of STABLE_CYCLES-1 clocks or fewer has no effect on any output.
- R3: A filtered SDA fall while filtered SCL is high gives a one-clock start_det. A filtered SDA rise while filtered SCL is high gives a one-clock stop_det. Neither condition is counted as a data bit.
- R4: Bits are sampled on each filtered SCL rise and enter the byte MSB first. The bit counter advances exactly once on each filtered SCL fall that ends a high phase begun after START. Clocks 1 to 8 carry the byte and clock 9 is the acknowledge slot.
- R5: An address byte is accepted when its bits 7:1 equal DEV_ADDR and bit 0 (direction, 0 = write) is 0. sda_oe is then 1 from the eighth filtered SCL fall until the ninth filtered SCL fall, and 0 after that.
- R6: An address byte that is not accepted (other address, or bit 0 = 1) gives no acknowledge and no byte_valid. All traffic is ignored until the next START or STOP.
- R7: After an accepted address, each completed byte gives one byte_valid pulse of one clock with the byte on rx_byte, and is acknowledged as in R5.
- R8: A repeated START in the middle of a byte discards the partial byte, clears the bit counter and returns to address reception.
- R9: Noise bursts on a slow SCL rising edge, made of runs shorter than STABLE_CYCLES clocks, do not add bit-count edges. A byte clocked with such edges is received unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low (open drain), 0 = release |
| rx_byte | output | 8 | Last received data byte |
| byte_valid | output | 1 | One-clock pulse when rx_byte holds a new data byte |
| start_det | output | 1 | One-clock pulse on START or repeated START |
| stop_det | output | 1 | One-clock pulse on STOP |

## Verification
A bit counter off by one moves the acknowledge by a whole SCL period. The master then reads a NACK at the ninth clock of that same byte, and the byte that byte_valid reports comes out rotated. A filter that lets a glitch through shows up at once as a spurious start_det or stop_det, or as a shifted byte within the transfer in progress. A wrong decision on address or direction is visible on sda_oe in the first acknowledge slot. A repeated START that fails to reset the byte engine corrupts the very next byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_ADDR   = 2'd1,
        ENG_DATA   = 2'd2,
        ENG_IGNORE = 2'd3
    } eng_state_e;

    localparam int BYTE_W   = 8;
    localparam int ACK_SLOT = BYTE_W;

    typedef struct packed {
        eng_state_e  state;
        logic [3:0]  bit_cnt;
        logic        got_high;
        logic [7:0]  shreg;
        logic [7:0]  data;
        logic        valid;
        logic        oe;
        logic        start;
        logic        stop;
    } eng_regs_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          level;
        logic [CW-1:0] cnt;
        logic          rise;
        logic          fall;
    } flt_regs_t;

    flt_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], raw_i};
        r_d.rise = 1'b0;
        r_d.fall = 1'b0;
        if (r_q.sync[1] != r_q.level) begin
            if (r_q.cnt == CW'(STABLE_CYCLES - 1)) begin
                r_d.level = r_q.sync[1];
                r_d.cnt   = '0;
                r_d.rise  = r_q.sync[1];
                r_d.fall  = ~r_q.sync[1];
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sync: 2'b11, level: 1'b1, cnt: '0, rise: 1'b0, fall: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign level_o = r_q.level;
    assign rise_o  = r_q.rise;
    assign fall_o  = r_q.fall;

    // R2: a level change must be backed by the synchronised sample
    p_level_backed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.level != $past(r_q.level)) |-> ($past(r_q.sync[1]) == r_q.level));

    // R2: the counter never passes its threshold
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(STABLE_CYCLES));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic scl_level,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_ev,
    output logic stop_ev
);
    always_comb begin
        start_ev = sda_fall & scl_level;
        stop_ev  = sda_rise & scl_level;
    end
endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_level,
    output logic       sda_oe,
    output logic [7:0] rx_byte,
    output logic       byte_valid,
    output logic       start_det,
    output logic       stop_det
);
    eng_regs_t e_q, e_d;
    logic      addr_ok;

    always_comb begin
        addr_ok = (e_q.shreg[7:1] == DEV_ADDR) && !e_q.shreg[0];
        e_d       = e_q;
        e_d.valid = 1'b0;
        e_d.start = start_ev;
        e_d.stop  = stop_ev;
        if (start_ev) begin
            e_d.state    = ENG_ADDR;
            e_d.bit_cnt  = '0;
            e_d.got_high = 1'b0;
            e_d.oe       = 1'b0;
        end else if (stop_ev) begin
            e_d.state    = ENG_IDLE;
            e_d.bit_cnt  = '0;
            e_d.got_high = 1'b0;
            e_d.oe       = 1'b0;
        end else if (e_q.state == ENG_ADDR || e_q.state == ENG_DATA) begin
            if (scl_rise) begin
                e_d.got_high = 1'b1;
                if (e_q.bit_cnt < 4'(ACK_SLOT)) begin
                    e_d.shreg = {e_q.shreg[6:0], sda_level};
                end
            end
            if (scl_fall && e_q.got_high) begin
                e_d.got_high = 1'b0;
                if (e_q.bit_cnt == 4'(ACK_SLOT)) begin
                    e_d.bit_cnt = '0;
                    e_d.oe      = 1'b0;
                end else if (e_q.bit_cnt == 4'(ACK_SLOT - 1)) begin
                    if (e_q.state == ENG_ADDR) begin
                        if (addr_ok) begin
                            e_d.state   = ENG_DATA;
                            e_d.bit_cnt = 4'(ACK_SLOT);
                            e_d.oe      = 1'b1;
                        end else begin
                            e_d.state   = ENG_IGNORE;
                            e_d.bit_cnt = '0;
                        end
                    end else begin
                        e_d.data    = e_q.shreg;
                        e_d.valid   = 1'b1;
                        e_d.bit_cnt = 4'(ACK_SLOT);
                        e_d.oe      = 1'b1;
                    end
                end else begin
                    e_d.bit_cnt = e_q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{state: ENG_IDLE, bit_cnt: '0, got_high: 1'b0, shreg: '0,
                     data: '0, valid: 1'b0, oe: 1'b0, start: 1'b0, stop: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign sda_oe     = e_q.oe;
    assign rx_byte    = e_q.data;
    assign byte_valid = e_q.valid;
    assign start_det  = e_q.start;
    assign stop_det   = e_q.stop;

    // R5: pull-down only inside the acknowledge slot
    p_oe_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.oe |-> (e_q.bit_cnt == 4'(ACK_SLOT) && e_q.state == ENG_DATA));

    // R6: an ignored transfer never drives the bus
    p_ignore_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ENG_IGNORE) |-> (!e_q.oe && !e_q.valid));

    // R7: byte_valid lasts one clock
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.valid |=> !e_q.valid);

    // R8: a START puts the engine back at bit zero of an address
    p_start_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (e_q.state == ENG_ADDR && e_q.bit_cnt == '0 && !e_q.oe));

    // R3: START and STOP never reported together
    p_cond_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({e_q.start, e_q.stop}));

    // R4: counter stays within byte plus acknowledge
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.bit_cnt <= 4'(ACK_SLOT));

endmodule

// File: rtl/i2c_oversampled_slave.sv
module i2c_oversampled_slave #(
    parameter logic [6:0] DEV_ADDR      = 7'h42,
    parameter int         STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] rx_byte,
    output logic       byte_valid,
    output logic       start_det,
    output logic       stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, lvl, rise, fall;
    logic              start_ev, stop_ev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cs_line_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g]),
            .fall_o  (fall[g])
        );
    end

    i2cs_bus_events u_ev (
        .scl_level (lvl[0]),
        .sda_rise  (rise[1]),
        .sda_fall  (fall[1]),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev)
    );

    i2cs_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .scl_rise   (rise[0]),
        .scl_fall   (fall[0]),
        .sda_level  (lvl[1]),
        .sda_oe     (sda_oe),
        .rx_byte    (rx_byte),
        .byte_valid (byte_valid),
        .start_det  (start_det),
        .stop_det   (stop_det)
    );

endmodule

// File: tb/sim_i2c_oversampled_slave.sv
module sim_i2c_oversampled_slave;
    localparam logic [6:0] ADDR = 7'h42;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, byte_valid, start_det, stop_det;
    logic [7:0] rx_byte;
    logic sda_line;

    int n_tests = 0, n_fail = 0;
    int n_bytes = 0, n_start = 0, n_stop = 0;
    logic [7:0] blog [0:15];

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_oversampled_slave #(.DEV_ADDR(ADDR), .STABLE_CYCLES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .rx_byte(rx_byte), .byte_valid(byte_valid),
        .start_det(start_det), .stop_det(stop_det)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                blog[n_bytes[3:0]] = rx_byte;
                n_bytes++;
            end
            if (start_det) n_start++;
            if (stop_det)  n_stop++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_rise_noisy();
        scl_m = 1'b1; ticks(2); scl_m = 1'b0; ticks(1);
        scl_m = 1'b1; ticks(3); scl_m = 1'b0; ticks(2);
        scl_m = 1'b1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; ticks(T);
        scl_m = 1'b1; ticks(T);
        sda_m = 1'b0; ticks(T);
        scl_m = 1'b0; ticks(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; ticks(T);
        scl_m = 1'b1; ticks(T);
        sda_m = 1'b1; ticks(T);
    endtask

    task automatic send_bit(input bit b, input bit noisy, output bit seen);
        sda_m = b; ticks(T/2);
        if (noisy) scl_rise_noisy(); else scl_m = 1'b1;
        ticks(T);
        seen = sda_line;
        ticks(T);
        scl_m = 1'b0; ticks(T/2);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit noisy, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(v[i], noisy, s);
        send_bit(1'b1, noisy, s);
        acked = !s;
        ticks(T/2);
    endtask

    task automatic t_reset();
        chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
        chk(byte_valid == 0 && start_det == 0 && stop_det == 0, "R1 pulses",
            {byte_valid, start_det, stop_det}, 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
    endtask

    task automatic t_write();
        bit a;
        int b0 = n_bytes, s0 = n_start, p0 = n_stop;
        bus_start();
        chk(n_start == s0 + 1, "R3 start_det", n_start - s0, 1);
        send_byte({ADDR, 1'b0}, 1'b0, a);
        chk(a, "R5 address ack", a, 1);
        chk(sda_oe == 0, "R5 release after slot", sda_oe, 0);
        chk(n_bytes == b0, "R4 address not reported", n_bytes - b0, 0);
        send_byte(8'hA5, 1'b0, a);
        chk(a, "R7 data ack", a, 1);
        send_byte(8'h3C, 1'b0, a);
        chk(a, "R7 data ack 2", a, 1);
        bus_stop();
        chk(n_stop == p0 + 1, "R3 stop_det", n_stop - p0, 1);
        chk(n_bytes == b0 + 2, "R7 byte count", n_bytes - b0, 2);
        chk(blog[b0[3:0]] == 8'hA5, "R4 byte0 MSB first", blog[b0[3:0]], 8'hA5);
        chk(blog[4'(b0 + 1)] == 8'h3C, "R7 byte1", blog[4'(b0 + 1)], 8'h3C);
        chk(n_start == s0 + 1, "R3 no extra start", n_start - s0, 1);
    endtask

    task automatic t_mismatch();
        bit a;
        int b0 = n_bytes;
        bus_start();
        send_byte({7'h13, 1'b0}, 1'b0, a);
        chk(!a, "R6 wrong address nack", a, 0);
        send_byte(8'h84, 1'b0, a);
        chk(!a, "R6 ignored data nack", a, 0);
        bus_stop();
        chk(n_bytes == b0, "R6 no byte_valid", n_bytes - b0, 0);
    endtask

    task automatic t_read_dir();
        bit a;
        int b0 = n_bytes;
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, a);
        chk(!a, "R6 read direction nack", a, 0);
        send_byte(8'h11, 1'b0, a);
        bus_stop();
        chk(n_bytes == b0 && !a, "R6 read ignored", n_bytes - b0, 0);
    endtask

    task automatic t_noisy();
        bit a;
        int b0 = n_bytes;
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, a);
        chk(a, "R9 noisy address ack", a, 1);
        send_byte(8'hC3, 1'b1, a);
        chk(a, "R9 noisy data ack", a, 1);
        bus_stop();
        chk(n_bytes == b0 + 1 && blog[b0[3:0]] == 8'hC3, "R9 noisy byte",
            blog[b0[3:0]], 8'hC3);
    endtask

    task automatic t_glitch();
        int s0 = n_start, p0 = n_stop;
        ticks(T);
        sda_m = 1'b0; ticks(3); sda_m = 1'b1; ticks(T);
        chk(n_start == s0 && n_stop == p0, "R2 short SDA pulse ignored",
            n_start - s0, 0);
        sda_m = 1'b0; ticks(4); sda_m = 1'b1; ticks(T);
        chk(n_start == s0 + 1 && n_stop == p0 + 1, "R2 full-length pulse seen",
            n_start - s0, 1);
    endtask

    task automatic t_restart();
        bit a, s;
        int b0 = n_bytes, s0 = n_start;
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b0, a);
        send_bit(1'b1, 1'b0, s);
        send_bit(1'b0, 1'b0, s);
        send_bit(1'b1, 1'b0, s);
        bus_start();
        chk(n_start == s0 + 2, "R8 repeated start seen", n_start - s0, 2);
        send_byte({ADDR, 1'b0}, 1'b0, a);
        chk(a, "R8 address after restart", a, 1);
        send_byte(8'h5A, 1'b0, a);
        bus_stop();
        chk(n_bytes == b0 + 1 && blog[b0[3:0]] == 8'h5A, "R8 byte after restart",
            blog[b0[3:0]], 8'h5A);
    endtask

    initial begin
        ticks(5);
        t_reset();
        rst_n = 1'b1;
        ticks(10);
        t_write();
        t_mismatch();
        t_read_dir();
        t_noisy();
        t_glitch();
        t_restart();
        ticks(20);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule